// File: doc/BRIEF.md
# AHB-to-APB Transfer Converter

This block sits on the slave side of an AHB bus and turns each AHB transfer into one APB4 transfer. It registers the AHB address-phase controls and stalls the AHB master through its ready output while the APB setup and access phases run. It forwards the APB completion, either OKAY or ERROR, back to the master. Slave selection and response multiplexing happen outside the block, so it drives one select and sees one ready, one read-data bus and one error line.

A transfer started from idle spends one extra wait cycle before its APB setup phase. A transfer whose address phase lands in the cycle that completes the previous transfer goes straight to setup, with no wait cycle. Neither data path looks at the direction bit. Write data is always presented on the APB write bus, and APB read data is always returned on the AHB read bus.

Top module: `ahb_apb_xfer_conv`

## Requirements
- R1: While reset is asserted, and after its release until the first transfer, hreadyout is 1 and hresp, psel and penable are 0.
- R2: An address phase starts a transfer only when hsel=1, hready_in=1 and htrans[1]=1 (NONSEQ 2'b10 or SEQ 2'b11). IDLE (2'b00), BUSY (2'b01), hsel=0 or hready_in=0 start nothing: psel stays 0 and hreadyout stays 1 in the following cycle.
- R3: Timing of a transfer accepted while idle. In the cycle after the address phase, hreadyout is 0 and psel is 0 (the wait cycle). In the next cycle psel=1 and penable=0 (setup). In the cycle after that, psel=1 and penable=1 (access).
- R4: The access phase holds psel=1, penable=1 and hreadyout=0 while pready=0. In the cycle where pready=1 (with pslverr=0), hreadyout is 1. If no new transfer was accepted in that cycle, psel and penable are 0 in the next cycle.
- R5: A transfer accepted in the cycle that completes the previous one enters setup in the very next cycle (psel=1, penable=0, its own paddr), with no wait cycle.
- R6: paddr and pwrite take the haddr and hwrite of the accepted address phase, and paddr, pwrite, pprot and pstrb stay unchanged from setup through completion.
- R7: pwdata equals hwdata during setup and access for reads and writes alike. hrdata equals prdata at completion for reads and writes alike.
- R8: pprot[0] = hprot[1] (privileged), pprot[1] = 0 (non-secure flag), and pprot[2] = NOT hprot[0] (instruction).
- R9: With ENDIAN=1, hsize gives 2^hsize bytes (0 = byte, 1 = halfword, 2 = word). pstrb bit i is 1 when byte lane i lies in the naturally aligned group of that many lanes containing the haddr lane (haddr low bits). A size that is the bus width or larger gives all ones.
- R10: With ENDIAN set to any other value (word-invariant big-endian), pstrb bit i equals the little-endian bit i XOR 3 (for a 32-bit or wider bus). Full-word strobes stay all ones.
- R11: An access completing with pready=1 and pslverr=1 gives hreadyout=0 in that cycle. The next cycle has hresp=1, hreadyout=0 and psel=0. The cycle after that has hresp=1 and hreadyout=1. hresp returns to 0 afterwards.
- R12: hresp is 0 in every cycle outside the two-cycle error response, including normal completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select for this block |
| hready_in | input | 1 | Bus-wide ready; the address phase is valid when it is high |
| htrans | input | 2 | Transfer type; bit 1 set means a real transfer |
| haddr | input | AW | Transfer address |
| hwrite | input | 1 | Direction, copied to pwrite |
| hsize | input | 3 | Transfer size as log2 of the byte count |
| hprot | input | 4 | Protection attributes |
| hwdata | input | DW | Write data of the current data phase |
| hreadyout | output | 1 | Data phase done when high, stall when low |
| hrdata | output | DW | Read data returned to the master |
| hresp | output | 1 | Error response |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access-phase flag |
| pwrite | output | 1 | APB direction |
| pprot | output | 3 | APB protection |
| paddr | output | AW | APB address |
| pwdata | output | DW | APB write data |
| pstrb | output | DW/8 | APB byte-lane strobes |
| pready | input | 1 | APB ready from the selected slave |
| prdata | input | DW | APB read data from the selected slave |
| pslverr | input | 1 | APB error from the selected slave |

## Verification
Two functions share one cycle in two cases: the completion of an APB access and the acceptance of the next AHB address phase. The bench provokes the first case by raising pready while presenting a new NONSEQ address phase. It then expects setup of the new address in the following cycle, with no wait cycle. The second case is the final error cycle, where hreadyout is already high. The bench runs that cycle with an IDLE htrans and judges that the block drops back to idle and clears hresp, instead of opening a new setup.

// File: rtl/ahb_apb_xfer_pkg.sv
package ahb_apb_xfer_pkg;

  typedef enum logic [2:0] {
    XS_IDLE   = 3'd0,
    XS_WAIT   = 3'd1,
    XS_SETUP  = 3'd2,
    XS_ACCESS = 3'd3,
    XS_ERR1   = 3'd4,
    XS_ERR2   = 3'd5
  } xfer_state_e;

endpackage

// File: rtl/ahb_apb_xfer_strb.sv
module ahb_apb_xfer_strb #(
  parameter int DW     = 32,
  parameter int ENDIAN = 1,
  localparam int NB    = DW / 8,
  localparam int LW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [2:0]    size,
  input  logic [LW-1:0] lane_addr,
  output logic [NB-1:0] strb
);

  localparam int SZ_FULL = $clog2(NB);
  localparam int LX      = (NB >= 4) ? 3 : NB - 1;

  logic          full_w;
  logic [NB-1:0] le_w;

  assign full_w = (int'(size) >= SZ_FULL);

  // lane sits in the aligned group of 2^size lanes holding the start lane
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      le_w[i] = full_w || ((LW'(i) >> size) == (lane_addr >> size));
    end
  end

  generate
    if (ENDIAN == 1) begin : g_le
      assign strb = le_w;
    end else begin : g_be
      for (genvar i = 0; i < NB; i++) begin : g_lane
        assign strb[i] = le_w[i ^ LX];
      end
    end
  endgenerate

endmodule

// File: rtl/ahb_apb_xfer_seq.sv
module ahb_apb_xfer_seq
  import ahb_apb_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pready,
  input  logic pslverr,
  output logic take,
  output logic hreadyout,
  output logic hresp,
  output logic psel,
  output logic penable
);

  xfer_state_e state_q, state_d;
  logic        ok_done;

  assign ok_done   = (state_q == XS_ACCESS) && pready && !pslverr;
  assign hreadyout = (state_q == XS_IDLE) || ok_done || (state_q == XS_ERR2);
  assign hresp     = (state_q == XS_ERR1) || (state_q == XS_ERR2);
  assign psel      = (state_q == XS_SETUP) || (state_q == XS_ACCESS);
  assign penable   = (state_q == XS_ACCESS);
  assign take      = start && hreadyout;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:   if (take) state_d = XS_WAIT;
      XS_WAIT:   state_d = XS_SETUP;
      XS_SETUP:  state_d = XS_ACCESS;
      XS_ACCESS: begin
        if (pready) begin
          if (pslverr)   state_d = XS_ERR1;
          else if (take) state_d = XS_SETUP;
          else           state_d = XS_IDLE;
        end
      end
      XS_ERR1:   state_d = XS_ERR2;
      XS_ERR2:   state_d = take ? XS_SETUP : XS_IDLE;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= XS_IDLE;
    else        state_q <= state_d;
  end

  // R3: setup is always followed by access
  p_setup_to_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  // R4: access is held while the slave is not ready
  p_hold_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (psel && penable));

  // R11: first error cycle is followed by the completing error cycle
  p_err_second_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

endmodule

// File: rtl/ahb_apb_xfer_conv.sv
module ahb_apb_xfer_conv #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int ENDIAN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready_in,
  input  logic [1:0]        htrans,
  input  logic [AW-1:0]     haddr,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [3:0]        hprot,
  input  logic [DW-1:0]     hwdata,
  output logic              hreadyout,
  output logic [DW-1:0]     hrdata,
  output logic              hresp,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [2:0]        pprot,
  output logic [AW-1:0]     paddr,
  output logic [DW-1:0]     pwdata,
  output logic [DW/8-1:0]   pstrb,
  input  logic              pready,
  input  logic [DW-1:0]     prdata,
  input  logic              pslverr
);

  localparam int NB = DW / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          start_w, take_w;
  logic [NB-1:0] strb_w;

  assign start_w = hsel && hready_in && htrans[1];

  ahb_apb_xfer_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start_w),
    .pready    (pready),
    .pslverr   (pslverr),
    .take      (take_w),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .psel      (psel),
    .penable   (penable)
  );

  ahb_apb_xfer_strb #(.DW(DW), .ENDIAN(ENDIAN)) u_strb (
    .size      (hsize),
    .lane_addr (haddr[LW-1:0]),
    .strb      (strb_w)
  );

  logic [AW-1:0] paddr_q, paddr_d;
  logic          pwrite_q, pwrite_d;
  logic [2:0]    pprot_q, pprot_d;
  logic [NB-1:0] pstrb_q, pstrb_d;

  always_comb begin
    paddr_d  = paddr_q;
    pwrite_d = pwrite_q;
    pprot_d  = pprot_q;
    pstrb_d  = pstrb_q;
    if (take_w) begin
      paddr_d  = haddr;
      pwrite_d = hwrite;
      pprot_d  = {~hprot[0], 1'b0, hprot[1]};
      pstrb_d  = strb_w;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q  <= '0;
      pwrite_q <= 1'b0;
      pprot_q  <= '0;
      pstrb_q  <= '0;
    end else begin
      paddr_q  <= paddr_d;
      pwrite_q <= pwrite_d;
      pprot_q  <= pprot_d;
      pstrb_q  <= pstrb_d;
    end
  end

  assign paddr  = paddr_q;
  assign pwrite = pwrite_q;
  assign pprot  = pprot_q;
  assign pstrb  = pstrb_q;

  // direction-blind data paths
  assign pwdata = hwdata;
  assign hrdata = prdata;

  // R6: address held from setup into access
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (psel && penable) |-> $stable(paddr));

  // R6: strobes held from setup into access
  p_strb_stable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (psel && penable) |-> $stable(pstrb));

endmodule

// File: tb/ahb_apb_xfer_conv_tb_top.sv
module ahb_apb_xfer_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsel, hwrite, pready, pslverr, hrdy_block;
  logic        hready_in;
  logic [1:0]  htrans;
  logic [15:0] haddr;
  logic [2:0]  hsize;
  logic [3:0]  hprot;
  logic [31:0] hwdata, prdata;

  logic        hreadyout, hresp, psel, penable, pwrite;
  logic [31:0] hrdata, pwdata;
  logic [2:0]  pprot;
  logic [15:0] paddr;
  logic [3:0]  pstrb;

  logic        be_hreadyout, be_hresp, be_psel, be_penable, be_pwrite;
  logic [31:0] be_hrdata, be_pwdata;
  logic [2:0]  be_pprot;
  logic [15:0] be_paddr;
  logic [3:0]  be_pstrb;

  int checks = 0;
  int errs   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign hready_in = hreadyout & ~hrdy_block;

  ahb_apb_xfer_conv #(.AW(16), .DW(32), .ENDIAN(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready_in(hready_in), .htrans(htrans),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
    .hreadyout(hreadyout), .hrdata(hrdata), .hresp(hresp), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pprot(pprot), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .pready(pready), .prdata(prdata), .pslverr(pslverr));

  ahb_apb_xfer_conv #(.AW(16), .DW(32), .ENDIAN(2)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready_in(hready_in), .htrans(htrans),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
    .hreadyout(be_hreadyout), .hrdata(be_hrdata), .hresp(be_hresp), .psel(be_psel),
    .penable(be_penable), .pwrite(be_pwrite), .pprot(be_pprot), .paddr(be_paddr),
    .pwdata(be_pwdata), .pstrb(be_pstrb), .pready(pready), .prdata(prdata), .pslverr(pslverr));

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  size;
    logic        wr;
    logic [3:0]  prot;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  le_strb;
    logic [3:0]  be_strb;
    logic [2:0]  xprot;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0101, 3'd0, 1'b1, 4'b0011, 32'hA1B2C3D4, 32'h11112222, 4'b0010, 4'b0100, 3'b001},
    '{16'h0102, 3'd1, 1'b0, 4'b0000, 32'h0BADF00D, 32'h33334444, 4'b1100, 4'b0011, 3'b100},
    '{16'h0200, 3'd2, 1'b1, 4'b0010, 32'hCAFE0001, 32'h55556666, 4'b1111, 4'b1111, 3'b101},
    '{16'h0103, 3'd0, 1'b0, 4'b0001, 32'h12345678, 32'h77778888, 4'b1000, 4'b0001, 3'b000},
    '{16'h0300, 3'd1, 1'b1, 4'b0011, 32'h9ABCDEF0, 32'h9999AAAA, 4'b0011, 4'b1100, 3'b001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_bus();
    hsel = 1'b0; htrans = 2'b00; pready = 1'b0; pslverr = 1'b0;
  endtask

  task automatic addr_phase(input logic [15:0] a, input logic [2:0] s,
                            input logic w, input logic [3:0] p);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hsize = s; hwrite = w; hprot = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hrdy_block = 1'b0; idle_bus();
    haddr = '0; hsize = '0; hwrite = 1'b0; hprot = '0; hwdata = '0; prdata = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 hreadyout in reset", hreadyout, 1);
    chk("R1 psel in reset", psel, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 hreadyout after reset", hreadyout, 1);
    chk("R1 hresp after reset", hresp, 0);
    chk("R1 psel/penable after reset", {psel, penable}, 0);

    // R2: address phases that must not start a transfer
    addr_phase(16'h0010, 3'd2, 1'b1, 4'h0); htrans = 2'b00;
    tick(); chk("R2 IDLE htrans psel", psel, 0); chk("R2 IDLE htrans hreadyout", hreadyout, 1);
    htrans = 2'b01;
    tick(); chk("R2 BUSY htrans hreadyout", hreadyout, 1);
    htrans = 2'b10; hsel = 1'b0;
    tick(); chk("R2 hsel low hreadyout", hreadyout, 1);
    hsel = 1'b1; hrdy_block = 1'b1;
    tick(); chk("R2 hready_in low hreadyout", hreadyout, 1);
    hrdy_block = 1'b0; idle_bus();
    tick(); chk("R2 nothing started psel", psel, 0);

    // table walk: one transfer per vector, one pready wait each
    foreach (VECS[k]) begin
      addr_phase(VECS[k].addr, VECS[k].size, VECS[k].wr, VECS[k].prot);
      tick();
      chk("R3 wait hreadyout", hreadyout, 0);
      chk("R3 wait psel", psel, 0);
      idle_bus(); hwdata = VECS[k].wdata;
      tick();
      chk("R3 setup psel/penable", {psel, penable}, 2'b10);
      chk("R6 paddr", paddr, VECS[k].addr);
      chk("R6 pwrite", pwrite, VECS[k].wr);
      chk("R8 pprot", pprot, VECS[k].xprot);
      chk("R9 pstrb little-endian", pstrb, VECS[k].le_strb);
      chk("R10 pstrb word-invariant", be_pstrb, VECS[k].be_strb);
      chk("R7 pwdata follows hwdata", pwdata, VECS[k].wdata);
      tick();
      chk("R3 access psel/penable", {psel, penable}, 2'b11);
      chk("R4 stall hreadyout", hreadyout, 0);
      tick();
      chk("R4 held access", {psel, penable}, 2'b11);
      chk("R6 paddr held", paddr, VECS[k].addr);
      prdata = VECS[k].rdata; pready = 1'b1;
      #1;
      chk("R4 completion hreadyout", hreadyout, 1);
      chk("R7 hrdata follows prdata", hrdata, VECS[k].rdata);
      chk("R12 hresp on OKAY", hresp, 0);
      tick();
      pready = 1'b0;
      chk("R4 idle after completion", {psel, penable}, 2'b00);
      chk("R4 idle hreadyout", hreadyout, 1);
    end

    // R5: next address phase in the completing cycle
    addr_phase(16'h0040, 3'd2, 1'b1, 4'h2);
    tick(); idle_bus(); hwdata = 32'h0000_00AA;
    tick(); tick();
    addr_phase(16'h0080, 3'd2, 1'b0, 4'h2); pready = 1'b1;
    tick();
    idle_bus(); hwdata = 32'h0000_00BB;
    #1;
    chk("R5 follow-on setup no wait", {psel, penable}, 2'b10);
    chk("R5 follow-on paddr", paddr, 16'h0080);
    chk("R7 follow-on pwdata", pwdata, 32'h0000_00BB);
    tick(); pready = 1'b1;
    tick(); pready = 1'b0;
    chk("R4 follow-on done", psel, 0);

    // R11: error response
    addr_phase(16'h0044, 3'd2, 1'b1, 4'h0);
    tick(); idle_bus();
    tick(); tick();
    pready = 1'b1; pslverr = 1'b1;
    #1;
    chk("R11 error access not ready", hreadyout, 0);
    chk("R12 hresp before error cycles", hresp, 0);
    tick(); pready = 1'b0; pslverr = 1'b0;
    chk("R11 first error cycle", {hresp, hreadyout, psel}, 3'b100);
    tick();
    chk("R11 second error cycle", {hresp, hreadyout}, 2'b11);
    tick();
    chk("R12 hresp cleared", {hresp, hreadyout, psel}, 3'b010);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule